// File: doc/BRIEF.md
# Superframe Alignment Marker Generator

This block follows a frame-synchronous serial port whose frames carry two bearer channels and one signalling channel. It works out where each frame falls inside a 96-frame line superframe. At 125 µs per frame, one superframe lasts 12 ms. The block drives two markers. The transmit marker flags the port frame whose data becomes the first block of basic frame 1 on the line. The receive marker flags the port frame that delivers the data received at the start of basic frame 1.

The shape of the marker pulse depends on the sync format:

- **Short-frame format:** the marker is a single bit-clock pulse in the cycle right after the frame sync.
- **Long-frame format:** the marker is high for as long as its own frame sync is high.

In terminal role the transmit marker is always driven. In line role the transmit marker is an input by default. A high sample on that input, taken one cycle after the transmit sync rises, re-phases the transmit superframe. An output-enable bit turns the marker back into an output, and the block then keeps its own phase.

All logic runs on the bit clock. The rising edge of `clk` stands for the sampling edge of the bit clock. Syncs are active high.

Top module: `sf_align_marker`

## Requirements
- R1: The transmit frame counter counts modulo 96 and advances on every rising edge of `fs_tx`. The first transmit sync after reset opens frame 0. With no forcing, the transmit marker appears in exactly one frame out of every 96.
- R2: In short format (`long_fmt`=0), `tx_mark_out` is high for exactly one cycle in frame 0. That cycle is the one right after the cycle in which `fs_tx` rose.
- R3: In long format (`long_fmt`=1), `tx_mark_out` is high in frame 0 in every cycle that `fs_tx` is high, starting with the rising cycle itself.
- R4: In short format, `rx_mark` is high for one cycle, right after the rising edge of `fs_rx`, in a flagged receive frame.
- R5: In long format, `rx_mark` follows `fs_rx` for the whole of a flagged receive frame's sync.
- R6: A pulse on `rx_sf_start` flags the receive frame whose `fs_rx` rising edge comes first in a strictly later cycle. A pulse in the same cycle as a rising edge flags the next frame, not the current one.
- R7: Unless both `marker_en` and `sync_mode` are 1, `tx_mark_out`, `tx_mark_oe` and `rx_mark` stay 0, and `tx_mark_in` has no effect.
- R8: In terminal role (`line_role`=0), `tx_mark_oe` is 1 while the block is enabled, and `tx_mark_in` is ignored.
- R9: In line role with `tx_out_en`=0, `tx_mark_oe` and `tx_mark_out` are 0. `tx_mark_in` is sampled in the cycle after an `fs_tx` rising edge. A 1 makes the current frame frame 0, so the marker then recurs 96 frames after it.
- R10: In line role with `tx_out_en`=1, `tx_mark_oe` is 1, the marker is driven, and `tx_mark_in` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| marker_en | input | 1 | Marker generation enable |
| sync_mode | input | 1 | 1 = port in frame-sync format (markers allowed) |
| long_fmt | input | 1 | 0 = short-frame syncs, 1 = long-frame syncs |
| line_role | input | 1 | 0 = terminal role, 1 = line role |
| tx_out_en | input | 1 | Line role: drive transmit marker as output |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| rx_sf_start | input | 1 | One-cycle pulse: receive superframe start seen |
| tx_mark_in | input | 1 | Value on the transmit marker pin when used as input |
| tx_mark_out | output | 1 | Transmit marker drive value |
| tx_mark_oe | output | 1 | Transmit marker output enable |
| rx_mark | output | 1 | Receive marker |

## Verification
The hardest case to reach is a forced re-phase. While the marker pin is an input, its effect cannot be seen, so the stimulus forces alignment on a chosen frame and then sets `tx_out_en`. The reference model predicts the marker 96 frames after the forced frame and checks that it lands there, which confirms the counter was reloaded. The bench also places an `rx_sf_start` pulse exactly on an `fs_rx` rising edge, where the flag must skip a frame. It compares every cycle in both sync formats, including frames where force pulses are applied while forcing should be ignored.

// File: rtl/sf_align_marker.sv
module sf_align_marker #(
  parameter int SF_LEN = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic marker_en,
  input  logic sync_mode,
  input  logic long_fmt,
  input  logic line_role,
  input  logic tx_out_en,
  input  logic fs_tx,
  input  logic fs_rx,
  input  logic rx_sf_start,
  input  logic tx_mark_in,
  output logic tx_mark_out,
  output logic tx_mark_oe,
  output logic rx_mark
);
  localparam int CW = $clog2(SF_LEN);
  localparam logic [CW-1:0] LAST = CW'(SF_LEN - 1);

  logic [CW-1:0] tx_cnt, tx_nxt, tx_cur;
  logic fs_tx_q, fs_rx_q, tx_after, rx_after, rx_arm, rx_flag;

  wire active   = marker_en & sync_mode;
  wire tx_rise  = fs_tx & ~fs_tx_q;
  wire rx_rise  = fs_rx & ~fs_rx_q;
  wire tx_input = active & line_role & ~tx_out_en;
  wire do_force = tx_input & tx_after & tx_mark_in;

  assign tx_nxt = (tx_cnt == LAST) ? '0 : tx_cnt + CW'(1);
  assign tx_cur = tx_rise ? tx_nxt : tx_cnt;

  assign tx_mark_oe  = active & (~line_role | tx_out_en);
  assign tx_mark_out = tx_mark_oe &
                       (long_fmt ? (fs_tx & (tx_cur == '0)) : (tx_after & (tx_cnt == '0)));
  assign rx_mark     = active &
                       (long_fmt ? (fs_rx & (rx_rise ? rx_arm : rx_flag)) : (rx_after & rx_flag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_tx_q  <= 1'b0;
      fs_rx_q  <= 1'b0;
      tx_after <= 1'b0;
      rx_after <= 1'b0;
      tx_cnt   <= LAST;
      rx_arm   <= 1'b0;
      rx_flag  <= 1'b0;
    end else begin
      fs_tx_q  <= fs_tx;
      fs_rx_q  <= fs_rx;
      tx_after <= tx_rise;
      rx_after <= rx_rise;
      if (do_force)     tx_cnt <= '0;
      else if (tx_rise) tx_cnt <= tx_nxt;
      if (rx_rise) begin
        rx_flag <= rx_arm;
        rx_arm  <= rx_sf_start;
      end else begin
        rx_arm  <= rx_arm | rx_sf_start;
      end
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= LAST);

  // R2
  short_tx_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!long_fmt && tx_mark_out) |=> !(tx_mark_out && !long_fmt));

  // R5
  long_rx_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (long_fmt && rx_mark) |-> fs_rx);

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(marker_en && sync_mode) |-> !(tx_mark_out || tx_mark_oe || rx_mark));

  // R8
  terminal_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !line_role) |-> tx_mark_oe);

  // R9
  force_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_input && tx_after && tx_mark_in) |=> (tx_cnt == '0));

  // R9
  input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mark_oe |-> !tx_mark_out);
endmodule

// File: tb/test_sf_align_marker.sv
module test_sf_align_marker;
  localparam int CLK_PERIOD = 10;
  localparam int FLEN = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic marker_en = 1'b1, sync_mode = 1'b1, long_fmt = 1'b0;
  logic line_role = 1'b0, tx_out_en = 1'b0;
  logic fs_tx = 1'b0, fs_rx = 1'b0, rx_sf_start = 1'b0, tx_mark_in = 1'b0;
  logic tx_mark_out, tx_mark_oe, rx_mark;

  int checks = 0, fails = 0, tx_marks = 0;
  bit done = 0;
  string req = "R1";

  int  m_idx = 95;
  bit  m_ptx = 0, m_prx = 0, m_atx = 0, m_arx = 0, m_arm = 0, m_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sf_align_marker i_sf_align_marker (
    .clk(clk), .rst_n(rst_n), .marker_en(marker_en), .sync_mode(sync_mode),
    .long_fmt(long_fmt), .line_role(line_role), .tx_out_en(tx_out_en),
    .fs_tx(fs_tx), .fs_rx(fs_rx), .rx_sf_start(rx_sf_start), .tx_mark_in(tx_mark_in),
    .tx_mark_out(tx_mark_out), .tx_mark_oe(tx_mark_oe), .rx_mark(rx_mark));

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit en, oe, rt, rr, etx, erx;
    int cur;
    #1;
    en = marker_en && sync_mode;
    oe = en && (!line_role || tx_out_en);
    rt = fs_tx && !m_ptx;
    rr = fs_rx && !m_prx;
    cur = rt ? (m_idx + 1) % 96 : m_idx;
    etx = oe && (long_fmt ? (fs_tx && cur == 0) : (m_atx && m_idx == 0));
    erx = en && (long_fmt ? (fs_rx && (rr ? m_arm : m_flag)) : (m_arx && m_flag));
    check(req, tx_mark_oe, oe, "tx_mark_oe");
    check(req, tx_mark_out, etx, "tx_mark_out");
    check(req, rx_mark, erx, "rx_mark");
    if (tx_mark_out) tx_marks++;
    @(posedge clk);
    if (en && line_role && !tx_out_en && m_atx && tx_mark_in) m_idx = 0;
    else if (rt) m_idx = (m_idx + 1) % 96;
    if (rr) begin m_flag = m_arm; m_arm = rx_sf_start; end
    else m_arm = m_arm || rx_sf_start;
    m_atx = rt; m_arx = rr; m_ptx = fs_tx; m_prx = fs_rx;
    @(negedge clk);
  endtask

  // rx frames lag tx frames by 3 bits; rx_sf_start pulses at (frame, bit) = (sf_f, sf_b)
  task automatic run_frames(int n, int force_f, int sf_f, int sf_b);
    for (int f = 0; f < n; f++) begin
      for (int b = 0; b < FLEN; b++) begin
        int rb;
        rb = (b + FLEN - 3) % FLEN;
        fs_tx = long_fmt ? (b < 8) : (b == 0);
        fs_rx = long_fmt ? (rb < 8) : (rb == 0);
        tx_mark_in = (f == force_f) && (b == 1);
        rx_sf_start = (sf_f >= 0) && (f % 96 == sf_f) && (b == sf_b);
        step();
      end
    end
    fs_tx = 0; fs_rx = 0; tx_mark_in = 0; rx_sf_start = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    #1;
    check("R7", tx_mark_out, 1'b0, "reset tx_mark_out");
    check("R7", rx_mark, 1'b0, "reset rx_mark");
    rst_n = 1'b1;
    @(negedge clk);

    req = "R2"; tx_marks = 0;
    run_frames(200, -1, 10, 6);
    check("R1", tx_marks == 3, 1'b1, "marker count in 200 frames");

    req = "R3"; long_fmt = 1;
    run_frames(110, -1, 20, 6);
    req = "R5";
    run_frames(30, -1, 2, 9);

    req = "R6"; long_fmt = 0;
    run_frames(30, -1, 5, 3);
    req = "R4";
    run_frames(20, -1, 7, 10);

    req = "R9"; line_role = 1; tx_out_en = 0;
    run_frames(50, 17, -1, 0);
    tx_out_en = 1; tx_marks = 0;
    run_frames(110, -1, -1, 0);
    check("R9", tx_marks == 1, 1'b1, "marker after forced phase");

    req = "R10";
    run_frames(100, 30, 4, 2);

    req = "R9"; tx_out_en = 0; long_fmt = 1;
    run_frames(20, 3, -1, 0);
    tx_out_en = 1;
    run_frames(100, -1, -1, 0);
    long_fmt = 0;

    req = "R7"; tx_out_en = 0; sync_mode = 0;
    run_frames(40, 9, 3, 5);
    marker_en = 0; sync_mode = 1;
    run_frames(40, 12, 3, 5);
    marker_en = 1; tx_out_en = 1; tx_marks = 0;
    run_frames(100, -1, -1, 0);
    check("R7", tx_marks == 1, 1'b1, "phase kept while disabled");

    req = "R8"; line_role = 0; tx_out_en = 0;
    run_frames(100, 40, 6, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule